// File: doc/BRIEF.md
# Serial-Input CRC-16 Accumulator

This block folds a stream of bytes into a 16-bit cyclic remainder. It takes one data bit per clock. A byte is offered on a valid/ready handshake. Once a byte is accepted, the block spends eight cycles shifting its bits into the remainder register, lowest bit first. On each shift the register moves up by one place and the new data bit enters at the bottom. Whenever a one falls out of the top, the remainder is reduced with the generator constant 0x002D.

No augmentation, reflection or final inversion is applied, so the value on the remainder output is the checksum of every byte accepted since the last clear. A one-cycle done pulse marks the cycle in which a byte's contribution is complete. A synchronous clear zeros the remainder and drops any byte that is half processed. A controller uses the block by pulsing clear at the start of a memory range, feeding the bytes of the range, and reading the remainder after the last done pulse.

Top module: `crc_serial_acc`

## Requirements
- R1: After reset the remainder output is 0x0000, byte_ready is 1 and byte_done is 0.
- R2: Each accepted byte adds exactly eight shift steps, using data bit 0 first and bit 7 last. The remainder carries over from byte to byte, and no final XOR or bit reversal is applied (feeding the single byte 0x01 from zero gives 0x0080).
- R3: On each step the register shifts left by one and the data bit enters bit 0. When no byte is in progress, the remainder holds its value.
- R4: When a shift sets bit 16, the 17-bit value is XORed with 0x002D and truncated to 16 bits (bytes 0x80, 0x00, 0x00 from zero give 0x002D).
- R5: byte_ready is low for exactly 8 cycles after a byte is accepted, and then returns high.
- R6: byte_valid and byte_data have no effect while byte_ready is low.
- R7: byte_done is a single-cycle pulse, raised in the first cycle in which the remainder holds the byte's final contribution.
- R8: A synchronous clear zeros the remainder and raises byte_ready in the next cycle. An interrupted byte produces no done pulse.
- R9: When clear and byte_valid are high in the same cycle, the clear wins and no byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of remainder and byte in progress |
| byte_valid | input | 1 | A byte is offered on byte_data |
| byte_data | input | 8 | Byte to fold into the remainder |
| byte_ready | output | 1 | Block is idle and accepts a byte this cycle |
| byte_done | output | 1 | One-cycle pulse when a byte has been folded in |
| remainder | output | 16 | Current 16-bit remainder |

## Verification
The hardest case to reach from the ports is a clear that lands part-way through a byte. In that case the half-shifted byte must leave no trace: no remainder change and no late done pulse. The stimulus accepts a byte, waits three cycles, and pulses clear. It then watches the done output over a window longer than a byte, with an empty scoreboard queue, so any stray pulse is flagged. The reduction path is reached on purpose with a three-byte sequence that pushes a single one out of bit 15 on the final step. Random streams of 1 to 256 bytes then cover reductions at every bit position.

// File: rtl/crc_acc_pkg.sv
package crc_acc_pkg;
  localparam int CRC_W = 16;

  // One shift-and-reduce step of the non-augmented serial remainder.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] rem,
                                                input logic din,
                                                input logic [CRC_W-1:0] poly);
    logic [CRC_W:0] wide;
    wide = {rem, din};
    if (wide[CRC_W]) crc_step = wide[CRC_W-1:0] ^ poly;
    else             crc_step = wide[CRC_W-1:0];
  endfunction
endpackage

// File: rtl/crc_bit_feeder.sv
module crc_bit_feeder #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              idle,
  output logic              step_fire,
  output logic              step_bit,
  output logic              last_step
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_idx;
  logic              busy;
  logic              take;

  assign take      = in_valid && !busy && !clear;
  assign idle      = !busy;
  assign step_fire = busy && !clear;
  assign step_bit  = shreg[0];
  assign last_step = step_fire && (bit_idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_idx <= '0;
      busy    <= 1'b0;
    end else if (clear) begin
      busy    <= 1'b0;
      bit_idx <= '0;
    end else if (take) begin
      shreg   <= in_data;
      bit_idx <= '0;
      busy    <= 1'b1;
    end else if (busy) begin
      shreg   <= shreg >> 1;
      bit_idx <= bit_idx + 1'b1;
      if (bit_idx == LAST) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/crc_rem_reg.sv
module crc_rem_reg
  import crc_acc_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 16'h002D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step_fire,
  input  logic             step_bit,
  output logic [CRC_W-1:0] rem
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rem <= '0;
    else if (clear)     rem <= '0;
    else if (step_fire) rem <= crc_step(rem, step_bit, POLY);
  end
endmodule

// File: rtl/crc_serial_acc.sv
module crc_serial_acc
  import crc_acc_pkg::*;
#(
  parameter int               DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY   = 16'h002D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  output logic              byte_ready,
  output logic              byte_done,
  output logic [CRC_W-1:0]  remainder
);
  logic step_fire;
  logic step_bit;
  logic last_step;
  logic done_q;

  crc_bit_feeder #(.DATA_W(DATA_W)) u_feed (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .in_valid(byte_valid), .in_data(byte_data),
    .idle(byte_ready), .step_fire(step_fire),
    .step_bit(step_bit), .last_step(last_step)
  );

  crc_rem_reg #(.POLY(POLY)) u_rem (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .step_fire(step_fire), .step_bit(step_bit), .rem(remainder)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= last_step && !clear;
  end

  assign byte_done = done_q;
endmodule

// File: rtl/crc_acc_checker.sv
module crc_acc_checker
  import crc_acc_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 16'h002D
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             byte_valid,
  input logic             byte_ready,
  input logic             byte_done,
  input logic [CRC_W-1:0] remainder,
  input logic             step_fire,
  input logic             step_bit
);
  logic [4:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (byte_valid && byte_ready && !clear) low_cnt <= '0;
    else if (!byte_ready && low_cnt != 5'd31) low_cnt <= low_cnt + 1'b1;
  end

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (remainder == '0) && byte_ready && !byte_done);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);

  assert_accept_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_ready && !clear) |=> !byte_ready);

  assert_window_eight_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> (low_cnt == 5'd8));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ready && !byte_valid && !clear) |=> $stable(remainder));

  assert_reduce_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> remainder == crc_step($past(remainder), $past(step_bit), POLY));

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && byte_valid) |=> byte_ready);
endmodule

bind crc_serial_acc crc_acc_checker #(.POLY(POLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .byte_valid(byte_valid),
  .byte_ready(byte_ready), .byte_done(byte_done), .remainder(remainder),
  .step_fire(step_fire), .step_bit(step_bit)
);

// File: tb/tb_crc_serial_acc.sv
module tb_crc_serial_acc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        byte_ready;
  logic        byte_done;
  logic [15:0] remainder;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model = '0;
  logic [15:0] expq[$];
  bit finished = 0;

  crc_serial_acc dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_ready(byte_ready), .byte_done(byte_done),
    .remainder(remainder)
  );

  always #10 clk = ~clk;

  function automatic logic [15:0] ref_byte(input logic [15:0] r, input logic [7:0] b);
    logic [15:0] x;
    logic top;
    x = r;
    for (int i = 0; i < 8; i++) begin
      top = x[15];
      x = {x[14:0], b[i]};
      if (top) x = x ^ 16'h002D;
    end
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: pop expected remainder on each done pulse.
  always @(negedge clk) begin
    if (rst_n && byte_done) begin
      if (expq.size() == 0) check(0, "R8 unexpected done", 32'(remainder), 32'hFFFF_FFFF);
      else begin
        logic [15:0] e;
        e = expq.pop_front();
        check(remainder == e, "R7 remainder at done", 32'(remainder), 32'(e));
      end
    end
  end

  task automatic send_byte(input logic [7:0] b, input bit chk_ready);
    int n;
    @(negedge clk);
    while (!byte_ready) @(negedge clk);
    byte_valid = 1'b1;
    byte_data  = b;
    model = ref_byte(model, b);
    expq.push_back(model);
    @(negedge clk);
    byte_valid = 1'b0;
    if (chk_ready) begin
      n = 0;
      while (!byte_ready && n < 20) begin
        n++;
        @(negedge clk);
      end
      check(n == 8, "R5 ready low cycles", 32'(n), 32'd8);
    end
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    model = '0;
    @(negedge clk);
    clear = 1'b0;
    check(remainder == 16'h0 && byte_ready, "R8 clear zeros", 32'(remainder), 32'h0);
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(remainder == 16'h0, "R1 reset remainder", 32'(remainder), 32'h0);
    check(byte_ready == 1'b1, "R1 reset ready", 32'(byte_ready), 32'h1);
    check(byte_done == 1'b0, "R1 reset done", 32'(byte_done), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: single byte 0x01, LSB first
    send_byte(8'h01, 1);
    settle();
    check(remainder == 16'h0080, "R2 byte 01", 32'(remainder), 32'h0080);

    // R4: reduction on overflow
    do_clear();
    send_byte(8'h80, 1);
    send_byte(8'h00, 0);
    send_byte(8'h00, 0);
    settle();
    check(remainder == 16'h002D, "R4 reduce 0x002D", 32'(remainder), 32'h002D);

    // R3: idle hold
    repeat (5) @(negedge clk);
    check(remainder == 16'h002D, "R3 idle hold", 32'(remainder), 32'h002D);

    // R6: input ignored while busy
    send_byte(8'h3C, 0);
    byte_valid = 1'b1;
    byte_data  = 8'hFF;
    repeat (5) @(negedge clk);
    check(!byte_ready, "R6 still busy", 32'(byte_ready), 32'h0);
    byte_valid = 1'b0;
    settle();
    check(remainder == model, "R6 busy input ignored", 32'(remainder), 32'(model));

    // R8: clear aborts byte in progress
    @(negedge clk);
    while (!byte_ready) @(negedge clk);
    byte_valid = 1'b1;
    byte_data  = 8'hA5;
    @(negedge clk);
    byte_valid = 1'b0;
    repeat (3) @(negedge clk);
    do_clear();
    settle();
    check(remainder == 16'h0, "R8 no residue", 32'(remainder), 32'h0);

    // R9: clear beats valid
    @(negedge clk);
    clear = 1'b1;
    byte_valid = 1'b1;
    byte_data = 8'h77;
    @(negedge clk);
    clear = 1'b0;
    byte_valid = 1'b0;
    check(byte_ready && remainder == 16'h0, "R9 clear wins", 32'({byte_ready, remainder}), 32'h10000);
    settle();
    check(remainder == 16'h0, "R9 no accept", 32'(remainder), 32'h0);

    // R2: random streams
    for (int s = 0; s < 6; s++) begin
      int len;
      len = (s == 0) ? 1 : (s == 1) ? 256 : $urandom_range(1, 256);
      do_clear();
      for (int k = 0; k < len; k++) send_byte(8'($urandom_range(0, 255)), (k % 37) == 0);
      settle();
      check(remainder == model, "R2 stream result", 32'(remainder), 32'(model));
      check(expq.size() == 0, "R7 all done pulses", 32'(expq.size()), 32'h0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule